// File: doc/BRIEF.md
# Receive Timestamp Matching Pool

This block holds a handful of receive timestamps until the packets they belong to can be claimed. A decoder upstream hands in one record at a time: a 64-bit capture time, a 16-bit sequence number, a 4-bit message class and a 12-bit digest. Later, a packet descriptor presents its message class and sequence number. If a live record carries both values, the block returns that record's time and digest and releases the slot. If no record matches, the block still answers, and flags a miss.

Records do not stay forever. Each slot ages in ticks of a free-running prescaler, and a record whose age reaches the timeout is dropped from the pool. Stale records are removed in the same cycle as any insertion that depends on them, so an insertion never fails because of a slot that has already timed out. When all slots hold live records, a new record is discarded and a one-cycle drop pulse is raised. When several live records match a query, the oldest one wins.

Top module: `rx_stamp_pool`

## Requirements
- R1: The pool holds DEPTH (default 4) records. An accepted insertion that finds no live-free slot is discarded, and `ins_drop` is 1 for exactly the cycle after the accepting edge. A stored record is never lost to a later insertion.
- R2: A lookup hits only when both the stored 4-bit message class equals `lk_mtype` and the stored 16-bit sequence number equals `lk_seq`. A difference in either field gives a miss.
- R3: A hit releases the record, so a repeated identical lookup misses and the slot can be reused.
- R4: A lookup that finds no match still completes: `res_valid` is 1 with `res_hit` 0, `res_time` 0 and `res_hash` 0.
- R5: When several live records match, the one inserted earliest is returned, and the later ones remain for later lookups.
- R6: A record expires once its age reaches TIMEOUT_TICKS ticks of a prescaler that ticks every PRESC_DIV cycles. It still hits while it is younger than (TIMEOUT_TICKS-1)*PRESC_DIV cycles, and it misses once more than TIMEOUT_TICKS*PRESC_DIV cycles have passed.
- R7: Expired records are pruned before an insertion, so an insertion into a pool full of expired records is stored and not dropped.
- R8: A lookup takes priority: `lk_ready` is always 1, and `ins_ready` is 0 in any cycle where `lk_valid` is 1. A held insertion is accepted in the first cycle without a lookup.
- R9: After reset the pool is empty, `res_valid` and `ins_drop` are 0 and `ins_ready` is 1.
- R10: The result of a lookup accepted at a clock edge is presented for exactly the following cycle, with `res_time` and `res_hash` equal to the stored time and digest on a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insertion request |
| ins_ready | output | 1 | Insertion accepted this cycle when valid |
| ins_time | input | 64 | Capture time of the record |
| ins_seq | input | 16 | Sequence number of the record |
| ins_mtype | input | 4 | Message class of the record |
| ins_hash | input | 12 | Digest stored with the record |
| ins_drop | output | 1 | Pulse: last accepted insertion found the pool full |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted (always 1) |
| lk_mtype | input | 4 | Message class to search for |
| lk_seq | input | 16 | Sequence number to search for |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | A matching record was found |
| res_time | output | 64 | Time of the matched record, 0 on a miss |
| res_hash | output | 12 | Digest of the matched record, 0 on a miss |

## Verification
A corrupted slot-valid bit shows as either a false hit or a false miss on the next lookup of that key, one cycle after the query, or as a wrong `ins_drop` value on the insertion that fills the pool. A broken age ordering shows as the newer of two equal-key records coming back first, visible on the very next lookup. A stuck or fast age counter shows only once a record reaches its timeout, so records are queried both well before and well after that window, and a pool full of stale records is filled again to catch a missed prune.

// File: rtl/rxts_pkg.sv
package rxts_pkg;

    localparam int TS_W   = 64;
    localparam int SEQ_W  = 16;
    localparam int TYPE_W = 4;
    localparam int HASH_W = 12;

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [SEQ_W-1:0]  seq;
        logic [TYPE_W-1:0] mtype;
        logic [HASH_W-1:0] hash;
    } stamp_t;

    localparam int STAMP_W = $bits(stamp_t);

    function automatic logic key_eq(stamp_t e, logic [TYPE_W-1:0] t, logic [SEQ_W-1:0] s);
        return (e.mtype == t) && (e.seq == s);
    endfunction

endpackage

// File: rtl/rxts_prescaler.sv
module rxts_prescaler #(
    parameter int unsigned DIV = 125000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/rxts_age_slot.sv
module rxts_age_slot #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int AW = $clog2(LIMIT + 1);

    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst || clear)
            age <= '0;
        else if (tick && (age != AW'(LIMIT)))
            age <= age + 1'b1;
    end

    assign expired = (age == AW'(LIMIT));
endmodule

// File: rtl/rxts_order.sv
module rxts_order #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] live,
    input  logic             ins_en,
    input  logic [DEPTH-1:0] ins_onehot,
    input  logic [DEPTH-1:0] match,
    output logic [DEPTH-1:0] first
);
    // older_q[i][j] set: slot j was filled before slot i
    logic [DEPTH-1:0] older_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                older_q[i] <= '0;
            else if (ins_en) begin
                if (ins_onehot[i])
                    older_q[i] <= live & ~ins_onehot;
                else
                    older_q[i] <= older_q[i] & ~ins_onehot;
            end
        end
        assign first[i] = match[i] & ~(|(match & older_q[i]));
    end
endmodule

// File: rtl/rx_stamp_pool.sv
module rx_stamp_pool
    import rxts_pkg::*;
#(
    parameter int          DEPTH         = 4,
    parameter int unsigned PRESC_DIV     = 125000,
    parameter int unsigned TIMEOUT_TICKS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [TS_W-1:0]   ins_time,
    input  logic [SEQ_W-1:0]  ins_seq,
    input  logic [TYPE_W-1:0] ins_mtype,
    input  logic [HASH_W-1:0] ins_hash,
    output logic              ins_drop,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [TYPE_W-1:0] lk_mtype,
    input  logic [SEQ_W-1:0]  lk_seq,
    output logic              res_valid,
    output logic              res_hit,
    output logic [TS_W-1:0]   res_time,
    output logic [HASH_W-1:0] res_hash
);
    stamp_t           slot_q [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] aged;
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] free_oh;
    logic [DEPTH-1:0] match;
    logic [DEPTH-1:0] first;
    logic [DEPTH-1:0] taken;
    logic             tick;
    logic             has_free;
    logic             ins_fire;
    logic             ins_en;
    logic             hit_any;
    logic [STAMP_W-1:0] sel_bits;
    stamp_t           sel;
    stamp_t           new_rec;

    rxts_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    // Lookups always win the cycle
    assign lk_ready  = 1'b1;
    assign ins_ready = ~lk_valid;
    assign ins_fire  = ins_valid & ins_ready;

    // Pruning: a record at its timeout is not live this cycle
    assign live     = valid_q & ~aged;
    assign free_oh  = ~live & (live + 1'b1);
    assign has_free = |free_oh;
    assign ins_en   = ins_fire & has_free;

    assign new_rec = '{ts: ins_time, seq: ins_seq, mtype: ins_mtype, hash: ins_hash};

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rxts_age_slot #(.LIMIT(TIMEOUT_TICKS)) u_age (
            .clk     (clk),
            .rst     (rst),
            .clear   (ins_en & free_oh[i]),
            .tick    (tick),
            .expired (aged[i])
        );

        assign match[i] = live[i] & key_eq(slot_q[i], lk_mtype, lk_seq);

        always_ff @(posedge clk) begin
            if (rst)
                slot_q[i] <= '0;
            else if (ins_en && free_oh[i])
                slot_q[i] <= new_rec;
        end
    end

    rxts_order #(.DEPTH(DEPTH)) u_order (
        .clk        (clk),
        .rst        (rst),
        .live       (live),
        .ins_en     (ins_en),
        .ins_onehot (free_oh),
        .match      (match),
        .first      (first)
    );

    assign hit_any = |first;
    assign taken   = lk_valid ? first : '0;

    always_comb begin
        sel_bits = '0;
        for (int i = 0; i < DEPTH; i++)
            if (first[i])
                sel_bits = sel_bits | slot_q[i];
    end
    assign sel = stamp_t'(sel_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= '0;
            ins_drop  <= 1'b0;
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_time  <= '0;
            res_hash  <= '0;
        end else begin
            valid_q   <= (live & ~taken) | (ins_en ? free_oh : '0);
            ins_drop  <= ins_fire & ~has_free;
            res_valid <= lk_valid;
            res_hit   <= lk_valid & hit_any;
            res_time  <= (lk_valid && hit_any) ? sel.ts : '0;
            res_hash  <= (lk_valid && hit_any) ? sel.hash : '0;
        end
    end
endmodule

// File: rtl/rx_stamp_pool_chk.sv
module rx_stamp_pool_chk #(
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic             ins_drop,
    input logic             lk_valid,
    input logic             res_valid,
    input logic [DEPTH-1:0] first
);
    assert_result_follows_R10: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    assert_no_spurious_result_R10: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    assert_lookup_priority_R8: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> !ins_ready);

    assert_drop_after_attempt_R1: assert property (@(posedge clk) disable iff (rst)
        ins_drop |-> $past(ins_valid && ins_ready));

    assert_single_winner_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(first));
endmodule

bind rx_stamp_pool rx_stamp_pool_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .ins_drop  (ins_drop),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .first     (first)
);

// File: tb/tb_rx_stamp_pool.sv
module tb_rx_stamp_pool;
    localparam int PRESC = 4;
    localparam int TMO   = 12;
    localparam int STALE = (TMO + 3) * PRESC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [63:0] ins_time = '0;
    logic [15:0] ins_seq = '0;
    logic [3:0]  ins_mtype = '0;
    logic [11:0] ins_hash = '0;
    logic        ins_drop;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [3:0]  lk_mtype = '0;
    logic [15:0] lk_seq = '0;
    logic        res_valid;
    logic        res_hit;
    logic [63:0] res_time;
    logic [11:0] res_hash;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    rx_stamp_pool #(.DEPTH(4), .PRESC_DIV(PRESC), .TIMEOUT_TICKS(TMO)) dut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_time(ins_time),
        .ins_seq(ins_seq), .ins_mtype(ins_mtype), .ins_hash(ins_hash),
        .ins_drop(ins_drop),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_mtype(lk_mtype), .lk_seq(lk_seq),
        .res_valid(res_valid), .res_hit(res_hit), .res_time(res_time), .res_hash(res_hash)
    );

    typedef struct packed {
        logic        is_lk;
        logic [3:0]  mt;
        logic [15:0] seq;
        logic [63:0] tm;
        logic        hit;
    } vec_t;

    // Insertions store hash = tm[11:0]; lookups expect time tm on a hit
    localparam vec_t VECS [12] = '{
        '{1'b0, 4'd1, 16'h0010, 64'd100, 1'b0},
        '{1'b0, 4'd1, 16'h0011, 64'd200, 1'b0},
        '{1'b1, 4'd1, 16'h0011, 64'd200, 1'b1},  // R2 hit on both fields
        '{1'b1, 4'd2, 16'h0010, 64'd0,   1'b0},  // R2 class differs
        '{1'b1, 4'd1, 16'h0012, 64'd0,   1'b0},  // R2 sequence differs
        '{1'b1, 4'd1, 16'h0010, 64'd100, 1'b1},
        '{1'b1, 4'd1, 16'h0010, 64'd0,   1'b0},  // R3 freed by hit
        '{1'b0, 4'd3, 16'h0005, 64'd300, 1'b0},
        '{1'b0, 4'd3, 16'h0005, 64'd400, 1'b0},
        '{1'b1, 4'd3, 16'h0005, 64'd300, 1'b1},  // R5 oldest first
        '{1'b1, 4'd3, 16'h0005, 64'd400, 1'b1},
        '{1'b1, 4'd3, 16'h0005, 64'd0,   1'b0}   // R4 miss completes
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic do_ins(input logic [3:0] mt, input logic [15:0] sq,
                          input logic [63:0] tm, output logic drop);
        @(negedge clk);
        ins_valid = 1'b1; ins_mtype = mt; ins_seq = sq;
        ins_time = tm; ins_hash = tm[11:0];
        @(posedge clk); #1;
        drop = ins_drop;
        ins_valid = 1'b0;
    endtask

    task automatic do_lk(input logic [3:0] mt, input logic [15:0] sq,
                         output logic rv, output logic hit,
                         output logic [63:0] tm, output logic [11:0] hs);
        @(negedge clk);
        lk_valid = 1'b1; lk_mtype = mt; lk_seq = sq;
        @(posedge clk); #1;
        rv = res_valid; hit = res_hit; tm = res_time; hs = res_hash;
        lk_valid = 1'b0;
    endtask

    task automatic expect_lk(string tag, input logic [3:0] mt, input logic [15:0] sq,
                             input logic ehit, input logic [63:0] etm);
        logic rv, hit;
        logic [63:0] tm;
        logic [11:0] hs;
        do_lk(mt, sq, rv, hit, tm, hs);
        chk({tag, " res_valid"}, 64'(rv), 64'd1);
        chk({tag, " res_hit"}, 64'(hit), 64'(ehit));
        chk({tag, " res_time"}, tm, ehit ? etm : 64'd0);
        chk({tag, " res_hash"}, 64'(hs), ehit ? 64'(etm[11:0]) : 64'd0);
    endtask

    task automatic expect_ins(string tag, input logic [3:0] mt, input logic [15:0] sq,
                              input logic [63:0] tm, input logic edrop);
        logic d;
        do_ins(mt, sq, tm, d);
        chk({tag, " ins_drop"}, 64'(d), 64'(edrop));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R9 reset state
        chk("R9 ins_ready", 64'(ins_ready), 64'd1);
        chk("R9 lk_ready", 64'(lk_ready), 64'd1);
        chk("R9 res_valid", 64'(res_valid), 64'd0);
        chk("R9 ins_drop", 64'(ins_drop), 64'd0);
        expect_lk("R9 empty pool", 4'd1, 16'h0010, 1'b0, 64'd0);

        // Table walk
        foreach (VECS[k]) begin
            if (VECS[k].is_lk)
                expect_lk($sformatf("R2/R3/R5 vec%0d", k), VECS[k].mt, VECS[k].seq,
                          VECS[k].hit, VECS[k].tm);
            else
                expect_ins($sformatf("R1 vec%0d", k), VECS[k].mt, VECS[k].seq,
                           VECS[k].tm, 1'b0);
        end

        // R10: strobe lasts one cycle
        @(posedge clk); #1;
        chk("R10 res_valid drops", 64'(res_valid), 64'd0);

        // R1: capacity and drop
        for (int i = 0; i < 4; i++)
            expect_ins("R1 fill", 4'd5, 16'(i), 64'(1000 + i), 1'b0);
        expect_ins("R1 full", 4'd5, 16'd9, 64'd2000, 1'b1);
        @(posedge clk); #1;
        chk("R1 drop one cycle", 64'(ins_drop), 64'd0);
        expect_lk("R1 dropped record absent", 4'd5, 16'd9, 1'b0, 64'd0);
        for (int i = 0; i < 4; i++)
            expect_lk("R1 kept", 4'd5, 16'(i), 1'b1, 64'(1000 + i));

        // R8: lookup served first, insertion held
        @(negedge clk);
        lk_valid = 1'b1; lk_mtype = 4'd7; lk_seq = 16'h0077;
        ins_valid = 1'b1; ins_mtype = 4'd7; ins_seq = 16'h0077;
        ins_time = 64'd777; ins_hash = 12'd777;
        #1;
        chk("R8 ins_ready low", 64'(ins_ready), 64'd0);
        @(posedge clk); #1;
        chk("R8 lookup before insert", 64'(res_hit), 64'd0);
        chk("R8 lookup result", 64'(res_valid), 64'd1);
        lk_valid = 1'b0;
        #1;
        chk("R8 ins_ready back", 64'(ins_ready), 64'd1);
        @(posedge clk); #1;
        ins_valid = 1'b0;
        expect_lk("R8 held insert stored", 4'd7, 16'h0077, 1'b1, 64'd777);

        // R6: hit while young, miss when stale
        expect_ins("R6 young", 4'd8, 16'h0001, 64'd800, 1'b0);
        repeat (5) @(posedge clk);
        expect_lk("R6 young hit", 4'd8, 16'h0001, 1'b1, 64'd800);
        expect_ins("R6 old", 4'd8, 16'h0002, 64'd900, 1'b0);
        repeat (STALE) @(posedge clk);
        expect_lk("R6 stale miss", 4'd8, 16'h0002, 1'b0, 64'd0);

        // R7: pruning frees a full pool of stale records
        for (int i = 0; i < 4; i++)
            expect_ins("R7 fill", 4'd9, 16'(i), 64'(3000 + i), 1'b0);
        repeat (STALE) @(posedge clk);
        expect_ins("R7 insert after prune", 4'd10, 16'h00aa, 64'd4000, 1'b0);
        expect_lk("R7 stale gone", 4'd9, 16'd0, 1'b0, 64'd0);
        expect_lk("R7 new stored", 4'd10, 16'h00aa, 1'b1, 64'd4000);

        summary();
        $finish;
    end
endmodule